// File: doc/BRIEF.md
# RTC Shadow Register Update Controller

This block stands between a byte-wide host register port and the live timekeeping and alarm state of a real-time clock. The host never writes the running counters or the active alarm directly. It fills a set of seven time buffer bytes or seven alarm buffer bytes, then sets a request bit in an update-control register. After a programmable delay, counted in ticks of a clock-enable strobe, the block moves the buffered values into place and drops the request bit by itself.

Three request bits exist. The time-write request produces a one-cycle load strobe toward the counters, with the buffered time alongside it. The snapshot request copies the running time into a readable capture bank, so that the host can read all seven bytes as one coherent value. The alarm request copies the alarm buffer into the active alarm registers. A build parameter selects a variant where the alarm request stays set after its transfer until the host writes it to 0. The delay code bits and the spare bits of the control register are plain read/write storage that transfers leave untouched.

Register layout (8-bit addresses, 8-bit data): time bytes at 0x00–0x06 and alarm bytes at 0x08–0x0E, each in the order seconds, minutes, hours, weekday, date, month, year. Control sits at 0x10. In the control register, bit 0 is the time-write request, bit 1 the snapshot request, bit 2 the alarm request, bit 3 and bits 7:6 are spare, and bits 5:4 hold the delay code.

Top module: `rtc_shadow_update`

## Requirements
- R1: After reset, all outputs are 0. Reads of the time bytes return 0, and a read of the control register returns 0x30.
- R2: Writes to time bytes 0x00–0x06 raise no load strobe. Setting control bit 0 raises `time_load_o` for exactly one cycle when the delay expires. In that cycle `time_load_data_o` carries byte k of the buffer at bits 8k+7:8k.
- R3: The time-write request bit reads 1 while its transfer is pending and reads 0 once the load strobe has been issued.
- R4: Setting control bit 1 copies `live_time_i` into the capture bank when the delay expires, and then clears the bit. Reads of 0x00–0x06 return capture byte k and do not follow later changes of `live_time_i`.
- R5: Alarm bytes 0x08–0x0E read back as written and leave `alarm_o` unchanged. Setting control bit 2 copies them into `alarm_o` when the delay expires, with byte k at bits 8k+7:8k.
- R6: With ALM_AUTOCLR=1 the alarm request bit clears after its transfer. With ALM_AUTOCLR=0 it stays 1 until the host writes 0 to it.
- R7: The delay is loaded from the delay code in the same control write that sets the request. It counts only cycles where `tick_i` is high. The transfer happens on the N-th tick after the write, where N is DLY_C0..DLY_C3 for codes 0..3. While `tick_i` is low, no transfer completes.
- R8: The delay code resets to 3 (DLY_C3 ticks, the longest default).
- R9: While a request is pending, writing 0 to it does not cancel it, and writing 1 to it does not restart its delay.
- R10: Control bits 7:3 are read/write and keep their value across transfers.
- R11: Read data appears on `rdata_o` one cycle after `re_i`. Unmapped addresses such as 0x07 and 0x20 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Delay clock-enable strobe |
| addr_i | input | 8 | Host register address |
| wdata_i | input | 8 | Host write data |
| we_i | input | 1 | Host write enable |
| re_i | input | 1 | Host read enable |
| rdata_o | output | 8 | Host read data, registered |
| live_time_i | input | 56 | Running time from the counters, byte k at bits 8k+7:8k |
| time_load_o | output | 1 | One-cycle load strobe toward the counters |
| time_load_data_o | output | 56 | Buffered time to load |
| alarm_o | output | 56 | Active alarm registers |

## Verification
Four behaviours are checked on every cycle: the load strobe is a single-cycle pulse, a completed time transfer always clears its request, the capture bank and active alarm change only in the cycle after their own transfer, and a pending request survives until its own completion with no tick-less completions. The bench scenarios are what show the exact latency for each delay code, the coherent snapshot against a changing live time, the sticky alarm variant, the ignored cancel and restart writes, and the retained control bits.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NUM_TIME = 7;
  localparam int unsigned FIELD_W  = NUM_TIME * BYTE_W;
  localparam int unsigned NUM_REQ  = 3;

  // request bit positions in the control register
  localparam int unsigned REQ_TWR = 0;
  localparam int unsigned REQ_SNP = 1;
  localparam int unsigned REQ_ALM = 2;

  typedef struct packed {
    logic [1:0]         spare_hi;
    logic [1:0]         dly;
    logic               spare_lo;
    logic [NUM_REQ-1:0] req;
  } ctrl_t;
endpackage

// File: rtl/rtc_upd_timer.sv
module rtc_upd_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign done_o = busy_q && tick_i && (cnt_q == CNT_W'(1));
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= load_i;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q && tick_i) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/rtc_byte_bank.sv
module rtc_byte_bank #(
  parameter int unsigned NUM = 7,
  parameter int unsigned W   = 8,
  localparam int unsigned IDX_W = $clog2(NUM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             ld_i,
  input  logic [NUM*W-1:0] ld_data_i,
  output logic [NUM*W-1:0] q_o
);
  for (genvar b = 0; b < NUM; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q_o[b*W +: W] <= '0;
      else if (ld_i)                              q_o[b*W +: W] <= ld_data_i[b*W +: W];
      else if (we_i && idx_i == IDX_W'(b))        q_o[b*W +: W] <= wdata_i;
    end
  end
endmodule

// File: rtl/rtc_shadow_update.sv
module rtc_shadow_update
  import rtc_shadow_pkg::*;
#(
  parameter int unsigned       DLY_C0      = 2,
  parameter int unsigned       DLY_C1      = 5,
  parameter int unsigned       DLY_C2      = 9,
  parameter int unsigned       DLY_C3      = 20,
  parameter bit                ALM_AUTOCLR = 1'b1,
  parameter logic [ADDR_W-1:0] TIME_BASE   = 8'h00,
  parameter logic [ADDR_W-1:0] ALM_BASE    = 8'h08,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h10,
  parameter logic [1:0]        DLY_RST     = 2'd3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BYTE_W-1:0]  wdata_i,
  input  logic               we_i,
  input  logic               re_i,
  output logic [BYTE_W-1:0]  rdata_o,
  input  logic [FIELD_W-1:0] live_time_i,
  output logic               time_load_o,
  output logic [FIELD_W-1:0] time_load_data_o,
  output logic [FIELD_W-1:0] alarm_o
);
  localparam int unsigned DLY_M01 = (DLY_C0 > DLY_C1) ? DLY_C0 : DLY_C1;
  localparam int unsigned DLY_M23 = (DLY_C2 > DLY_C3) ? DLY_C2 : DLY_C3;
  localparam int unsigned DLY_MAX = (DLY_M01 > DLY_M23) ? DLY_M01 : DLY_M23;
  localparam int unsigned CNT_W   = $clog2(DLY_MAX + 1);
  localparam int unsigned IDX_W   = $clog2(NUM_TIME);

  function automatic logic [CNT_W-1:0] dly_ticks(input logic [1:0] code);
    case (code)
      2'd0:    return CNT_W'(DLY_C0);
      2'd1:    return CNT_W'(DLY_C1);
      2'd2:    return CNT_W'(DLY_C2);
      default: return CNT_W'(DLY_C3);
    endcase
  endfunction

  // address decode
  logic [ADDR_W-1:0] time_off, alm_off;
  logic              hit_time, hit_alm, wr_ctrl;
  logic [IDX_W-1:0]  time_idx, alm_idx;

  assign time_off = addr_i - TIME_BASE;
  assign alm_off  = addr_i - ALM_BASE;
  assign hit_time = time_off < ADDR_W'(NUM_TIME);
  assign hit_alm  = alm_off < ADDR_W'(NUM_TIME);
  assign time_idx = time_off[IDX_W-1:0];
  assign alm_idx  = alm_off[IDX_W-1:0];
  assign wr_ctrl  = we_i && (addr_i == CTRL_ADDR);

  ctrl_t wd, rb;
  assign wd = ctrl_t'(wdata_i);

  // control storage
  logic [1:0]         spare_hi_q, dly_q;
  logic               spare_lo_q;
  logic [NUM_REQ-1:0] req_q, req_d, busy, done, start;

  assign rb = '{spare_hi: spare_hi_q, dly: dly_q, spare_lo: spare_lo_q, req: req_q};

  always_comb begin
    for (int i = 0; i < NUM_REQ; i++) begin
      start[i] = wr_ctrl && wd.req[i] && !busy[i];
      req_d[i] = req_q[i];
      if (start[i])                                            req_d[i] = 1'b1;
      else if (done[i] && ((i != REQ_ALM) || ALM_AUTOCLR))     req_d[i] = 1'b0;
      else if (wr_ctrl && !busy[i])                            req_d[i] = wd.req[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q      <= '0;
      spare_hi_q <= '0;
      spare_lo_q <= 1'b0;
      dly_q      <= DLY_RST;
    end else begin
      req_q <= req_d;
      if (wr_ctrl) begin
        spare_hi_q <= wd.spare_hi;
        spare_lo_q <= wd.spare_lo;
        dly_q      <= wd.dly;
      end
    end
  end

  // one delay timer per request
  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    rtc_upd_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start[g]),
      .load_i  (dly_ticks(wd.dly)),
      .tick_i  (tick_i),
      .busy_o  (busy[g]),
      .done_o  (done[g])
    );
  end

  // storage banks
  logic [FIELD_W-1:0] wbuf_q, abuf_q, snap_q;

  rtc_byte_bank #(.NUM(NUM_TIME), .W(BYTE_W)) u_wbuf (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i && hit_time), .idx_i(time_idx),
    .wdata_i(wdata_i), .ld_i(1'b0), .ld_data_i('0), .q_o(wbuf_q));

  rtc_byte_bank #(.NUM(NUM_TIME), .W(BYTE_W)) u_abuf (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i && hit_alm), .idx_i(alm_idx),
    .wdata_i(wdata_i), .ld_i(1'b0), .ld_data_i('0), .q_o(abuf_q));

  rtc_byte_bank #(.NUM(NUM_TIME), .W(BYTE_W)) u_snap (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(1'b0), .idx_i('0),
    .wdata_i('0), .ld_i(done[REQ_SNP]), .ld_data_i(live_time_i), .q_o(snap_q));

  rtc_byte_bank #(.NUM(NUM_TIME), .W(BYTE_W)) u_alarm (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(1'b0), .idx_i('0),
    .wdata_i('0), .ld_i(done[REQ_ALM]), .ld_data_i(abuf_q), .q_o(alarm_o));

  assign time_load_data_o = wbuf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_load_o <= 1'b0;
      rdata_o     <= '0;
    end else begin
      time_load_o <= done[REQ_TWR];
      if (re_i) begin
        if (hit_time)                rdata_o <= snap_q[int'(time_idx)*BYTE_W +: BYTE_W];
        else if (hit_alm)            rdata_o <= abuf_q[int'(alm_idx)*BYTE_W +: BYTE_W];
        else if (addr_i == CTRL_ADDR) rdata_o <= rb;
        else                         rdata_o <= '0;
      end
    end
  end
endmodule

// File: rtl/rtc_shadow_update_chk.sv
module rtc_shadow_update_chk
  import rtc_shadow_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic               time_load_o,
  input logic [FIELD_W-1:0] alarm_o,
  input logic [FIELD_W-1:0] snap_q,
  input logic [NUM_REQ-1:0] req_q,
  input logic [NUM_REQ-1:0] busy,
  input logic [NUM_REQ-1:0] done
);
  AST_LOAD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_load_o |=> !time_load_o); // R2

  AST_TWR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done[REQ_TWR] |=> (time_load_o && !req_q[REQ_TWR])); // R3

  AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(snap_q) |-> $past(done[REQ_SNP])); // R4

  AST_ALARM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(alarm_o) |-> $past(done[REQ_ALM])); // R5

  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ((~busy & $past(busy)) == '0)); // R7

  AST_PEND_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(busy & ~done) & ~(busy & req_q)) == '0)); // R9
endmodule

bind rtc_shadow_update rtc_shadow_update_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .time_load_o (time_load_o),
  .alarm_o     (alarm_o),
  .snap_q      (snap_q),
  .req_q       (req_q),
  .busy        (busy),
  .done        (done)
);

// File: tb/rtc_shadow_update_bench.sv
module rtc_shadow_update_bench;
  import rtc_shadow_pkg::*;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               tick_en = 1'b1;
  logic [7:0]         addr = '0, wdata = '0;
  logic               we = 1'b0, re = 1'b0;
  logic [FIELD_W-1:0] live = '0;
  logic [7:0]         rdata, rdata_s;
  logic               tload, tload_s;
  logic [FIELD_W-1:0] tdata, tdata_s, alarm, alarm_s;
  int                 cyc = 0;
  int                 n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_shadow_update u_rtc_shadow_update (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_en), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .live_time_i(live),
    .time_load_o(tload), .time_load_data_o(tdata), .alarm_o(alarm));

  rtc_shadow_update #(.ALM_AUTOCLR(1'b0)) u_rtc_shadow_update_sticky (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_en), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata_s), .live_time_i(live),
    .time_load_o(tload_s), .time_load_data_o(tdata_s), .alarm_o(alarm_s));

  // {read, addr, data}: writes store data, reads expect data
  localparam logic [16:0] VEC [14] = '{
    {1'b0, 8'h08, 8'h11}, {1'b0, 8'h09, 8'h22}, {1'b0, 8'h0A, 8'h33},
    {1'b0, 8'h0B, 8'h44}, {1'b0, 8'h0C, 8'h55}, {1'b0, 8'h0D, 8'h66},
    {1'b0, 8'h0E, 8'h77}, {1'b1, 8'h08, 8'h11}, {1'b1, 8'h0B, 8'h44},
    {1'b1, 8'h0E, 8'h77}, {1'b0, 8'h10, 8'hC8}, {1'b1, 8'h10, 8'hC8},
    {1'b1, 8'h07, 8'h00}, {1'b1, 8'h20, 8'h00}
  };

  localparam logic [FIELD_W-1:0] T_EXP = {8'h63, 8'h0C, 8'h1F, 8'h04, 8'h17, 8'h2A, 8'h3B};
  localparam logic [FIELD_W-1:0] A_EXP = {8'h77, 8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'h11};
  localparam logic [FIELD_W-1:0] LIVE_A = {8'h63, 8'h0B, 8'h1E, 8'h03, 8'h12, 8'h2D, 8'h07};
  localparam logic [FIELD_W-1:0] LIVE_B = {8'h63, 8'h0B, 8'h1E, 8'h05, 8'h13, 8'h00, 8'h00};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic [7:0] ds);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(posedge clk);
    @(negedge clk);
    re = 1'b0;
    d = rdata; ds = rdata_s;
  endtask

  task automatic wait_load(output int t);
    t = -1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (tload) begin t = cyc; break; end
    end
  endtask

  task automatic wait_alarm(input logic [FIELD_W-1:0] exp, output int t);
    t = -1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (alarm == exp) begin t = cyc; break; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d, ds;
    int t0, t1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk("R1 alarm_o", 64'(alarm), 64'h0);
    chk("R1 time_load_o", 64'(tload), 64'h0);
    rd(8'h10, d, ds);
    chk("R1 R8 ctrl reset", 64'(d), 64'h30);
    rd(8'h00, d, ds);
    chk("R1 capture reset", 64'(d), 64'h0);

    // vector table
    for (int i = 0; i < 14; i++) begin
      if (VEC[i][16]) begin
        rd(VEC[i][15:8], d, ds);
        if (VEC[i][15:8] == 8'h10)     chk("R10 ctrl readback", 64'(d), 64'(VEC[i][7:0]));
        else if (VEC[i][15:8] >= 8'h08 && VEC[i][15:8] <= 8'h0E)
                                       chk("R5 alarm buffer readback", 64'(d), 64'(VEC[i][7:0]));
        else                           chk("R11 unmapped read", 64'(d), 64'(VEC[i][7:0]));
      end else begin
        wr(VEC[i][15:8], VEC[i][7:0]);
      end
    end
    chk("R5 alarm_o unchanged by buffer writes", 64'(alarm), 64'h0);

    // time write, code 0
    wr(8'h00, 8'h3B); wr(8'h01, 8'h2A); wr(8'h02, 8'h17); wr(8'h03, 8'h04);
    wr(8'h04, 8'h1F); wr(8'h05, 8'h0C); wr(8'h06, 8'h63);
    chk("R2 no strobe from buffer writes", 64'(tload), 64'h0);
    wr(8'h10, 8'hC9);
    t0 = cyc;
    chk("R2 no strobe right after request", 64'(tload), 64'h0);
    wait_load(t1);
    chk("R7 code0 latency", 64'(t1 - t0), 64'(2));
    chk("R2 load data", 64'(tdata), 64'(T_EXP));
    @(negedge clk);
    chk("R2 strobe one cycle", 64'(tload), 64'h0);
    rd(8'h10, d, ds);
    chk("R3 R10 ctrl after time transfer", 64'(d), 64'hC8);

    // alarm transfer, both variants
    wr(8'h10, 8'hCC);
    t0 = cyc;
    chk("R5 alarm_o before transfer", 64'(alarm), 64'h0);
    wait_alarm(A_EXP, t1);
    chk("R5 alarm latency", 64'(t1 - t0), 64'(2));
    chk("R5 alarm_o value", 64'(alarm), 64'(A_EXP));
    rd(8'h10, d, ds);
    chk("R6 autoclear alarm bit", 64'(d), 64'hC8);
    chk("R6 sticky alarm bit stays", 64'(ds), 64'hCC);
    chk("R6 sticky alarm_o", 64'(alarm_s), 64'(A_EXP));
    wr(8'h10, 8'hC8);
    rd(8'h10, d, ds);
    chk("R6 sticky alarm bit cleared by host", 64'(ds), 64'hC8);

    // code 3 with ignored cancel and restart
    wr(8'h10, 8'hF9);
    t0 = cyc;
    wr(8'h10, 8'h08);
    rd(8'h10, d, ds);
    chk("R9 cancel ignored, R10 other bits written", 64'(d), 64'h09);
    wr(8'h10, 8'h09);
    wait_load(t1);
    chk("R9 R7 code3 latency unchanged by restart", 64'(t1 - t0), 64'(20));
    rd(8'h10, d, ds);
    chk("R3 ctrl after code3 transfer", 64'(d), 64'h08);

    // tick gating, code 1
    tick_en = 1'b0;
    wr(8'h10, 8'h19);
    t1 = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (tload) t1 = 1;
    end
    chk("R7 no transfer without ticks", 64'(t1), 64'h0);
    rd(8'h10, d, ds);
    chk("R7 request held without ticks", 64'(d), 64'h19);
    tick_en = 1'b1;
    t0 = cyc;
    wait_load(t1);
    chk("R7 code1 latency in ticks", 64'(t1 - t0), 64'(5));

    // snapshot capture
    live = LIVE_A;
    wr(8'h10, 8'h0A);
    repeat (3) @(negedge clk);
    live = LIVE_B;
    for (int k = 0; k < 7; k++) begin
      rd(8'(k), d, ds);
      chk("R4 coherent capture byte", 64'(d), 64'(LIVE_A[k*8 +: 8]));
    end
    rd(8'h10, d, ds);
    chk("R4 snapshot bit cleared", 64'(d), 64'h08);
    wr(8'h10, 8'h0A);
    repeat (3) @(negedge clk);
    rd(8'h03, d, ds);
    chk("R4 second capture", 64'(d), 64'(LIVE_B[24 +: 8]));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule